// File: doc/BRIEF.md
# SMBus Slave Register-Write Decoder

This block is a slave on a two-wire SMBus segment. It watches the synchronized clock and data lines for Byte Write messages from an external controller. A message has a start condition, then a 7-bit address with a write bit, then a command byte, then a data byte, and ends with a stop condition. The block compares the received address with its own-address register. That register leaves reset holding a usable default, so the block works before the host programs anything. When the address matches, the block pulls the data line low in each of the three acknowledge slots. After the data byte has been acknowledged, the block writes that byte into the local control register chosen by the command byte. It also latches the byte as the most recent received data and sets a sticky status flag. The status flag, gated by an enable bit, drives an interrupt request.

The host reaches the block through a small synchronous parallel port. Through this port it reads and changes the own address, reads the latest received byte, clears the status flag by writing a one, and sets the interrupt enable. The local control registers appear on a flat output vector for the logic around the block.

Top module: `smbw_slave`

## Requirements
- R1: After reset the own address reads 0x44 (parameter DEF_ADDR), and the received-data byte, status flag, interrupt enable, all control registers, `irq` and `sdaDrvLow` are zero.
- R2: For a message whose address equals the own address and whose eighth bit (read/write) is 0, the block drives `sdaDrvLow` high during the acknowledge slot after the address, the one after the command and the one after the data byte.
- R3: If the address differs from the own address, or the read/write bit is 1, the block acknowledges none of the three bytes and changes no register.
- R4: On a completed matching message, a command value below NUM_REGS (4) writes the data byte into control register number `command`, which sits in bits [8*command+7 : 8*command] of `ctlRegs`. A command value at or above NUM_REGS writes no control register, but the block still acknowledges and still does everything in R5 and R6.
- R5: Host offset 1 returns the data byte of the most recent completed matching message.
- R6: Host offset 2 bit 0 is the status flag. A completed matching message sets it. A host write to offset 2 with bit 0 set clears it.
- R7: `irq` is high exactly when the status flag is set and the enable bit is set. The enable bit is host offset 3 bit 0.
- R8: A stop condition or a repeated start that arrives before the data acknowledge slot has ended aborts the message, and no register changes. A repeated start also begins a new message, which is decoded in full.
- R9: A host write to offset 0 loads bits [6:0] of the write data as the new own address, and later messages match against that value.
- R10: Host reads are registered: `hostRdata` shows, one clock after `hostAddr` is presented, the register at that offset (0 address, 1 received data, 2 status, 3 enable), with unused high bits read as 0.
- R11: The acknowledge drive begins only after an SCL falling edge, while SCL is low, and it is released after the next SCL falling edge. The block never drives the data line at any other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| sdaDrvLow | output | 1 | High to pull the bus data line low (open-drain enable) |
| hostWe | input | 1 | Host write strobe |
| hostAddr | input | 2 | Host register offset |
| hostWdata | input | 8 | Host write data |
| hostRdata | output | 8 | Host read data, registered |
| irq | output | 1 | Interrupt request |
| ctlRegs | output | NUM_REGS*8 | Flat vector of the local control registers |

## Verification
The assertions assume that the bus is far slower than `clk`. SCL must stay low for many clocks after each falling edge, so that the synchronizer delay still leaves the acknowledge drive starting while SCL is low. SDA must change only while SCL is low, except at start and stop conditions. The bench drives a bit-banged controller with a quarter-bit time of eight clocks and a wired-AND data line. It changes data only in SCL low phases. It varies addresses, read/write bits, commands, data, aborts and host actions at random, and adds directed cases for the default address, a repeated start and out-of-range commands.

// File: rtl/smbw_pkg.sv
package smbw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ACK_A, ST_CMD, ST_ACK_C, ST_DATA, ST_ACK_D, ST_SKIP
  } smbwState_e;

  typedef struct packed {
    logic       commit;
    logic [7:0] cmd;
    logic [7:0] data;
  } smbwStrobe_t;

  localparam logic [1:0] OFS_ADDR = 2'd0;
  localparam logic [1:0] OFS_DATA = 2'd1;
  localparam logic [1:0] OFS_STAT = 2'd2;
  localparam logic [1:0] OFS_EN   = 2'd3;
endpackage

// File: rtl/smbw_ctrl.sv
module smbw_ctrl
  import smbw_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclIn,
  input  logic        sdaIn,
  input  logic [6:0]  ownAddr,
  output logic        sdaDrvLow,
  output smbwStrobe_t stb
);
  localparam int BITS = 8;
  localparam int CNT_W = $clog2(BITS + 1);

  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic sclS, sdaS, sclD, sdaD;
  logic sclRise, sclFall, startDet, stopDet;
  smbwState_e state;
  logic [BITS-1:0] shReg, cmdReg, dataReg;
  logic [CNT_W-1:0] bitCnt;
  logic drvQ, commitQ;
  logic byteEnd;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclD    <= 1'b1;
      sdaD    <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
      sclD    <= sclS;
      sdaD    <= sdaS;
    end
  end

  assign sclS     = sclPipe[SYNC_STAGES-1];
  assign sdaS     = sdaPipe[SYNC_STAGES-1];
  assign sclRise  = sclS & ~sclD;
  assign sclFall  = ~sclS & sclD;
  assign startDet = sclS & sclD & sdaD & ~sdaS;
  assign stopDet  = sclS & sclD & ~sdaD & sdaS;
  assign byteEnd  = sclFall && (bitCnt == CNT_W'(BITS));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      shReg   <= '0;
      cmdReg  <= '0;
      dataReg <= '0;
      bitCnt  <= '0;
      drvQ    <= 1'b0;
      commitQ <= 1'b0;
    end else begin
      commitQ <= 1'b0;
      if (startDet) begin
        state  <= ST_ADDR;
        bitCnt <= '0;
        drvQ   <= 1'b0;
      end else if (stopDet) begin
        state <= ST_IDLE;
        drvQ  <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR, ST_CMD, ST_DATA: begin
            if (sclRise && bitCnt < CNT_W'(BITS)) begin
              shReg  <= {shReg[BITS-2:0], sdaS};
              bitCnt <= bitCnt + 1'b1;
            end else if (byteEnd) begin
              bitCnt <= '0;
              if (state == ST_ADDR) begin
                if (shReg == {ownAddr, 1'b0}) begin
                  state <= ST_ACK_A;
                  drvQ  <= 1'b1;
                end else begin
                  state <= ST_SKIP;
                end
              end else if (state == ST_CMD) begin
                cmdReg <= shReg;
                state  <= ST_ACK_C;
                drvQ   <= 1'b1;
              end else begin
                dataReg <= shReg;
                state   <= ST_ACK_D;
                drvQ    <= 1'b1;
              end
            end
          end
          ST_ACK_A, ST_ACK_C, ST_ACK_D: begin
            if (sclFall) begin
              drvQ   <= 1'b0;
              bitCnt <= '0;
              if (state == ST_ACK_A) state <= ST_CMD;
              else if (state == ST_ACK_C) state <= ST_DATA;
              else begin
                state   <= ST_SKIP;
                commitQ <= 1'b1;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sdaDrvLow  = drvQ;
  assign stb.commit = commitQ;
  assign stb.cmd    = cmdReg;
  assign stb.data   = dataReg;
endmodule

// File: rtl/smbw_dpath.sv
module smbw_dpath
  import smbw_pkg::*;
#(
  parameter int         NUM_REGS = 4,
  parameter logic [6:0] DEF_ADDR = 7'h44
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  smbwStrobe_t           stb,
  input  logic                  hostWe,
  input  logic [1:0]            hostAddr,
  input  logic [7:0]            hostWdata,
  output logic [7:0]            hostRdata,
  output logic [6:0]            ownAddr,
  output logic [7:0]            rxData,
  output logic                  statusBit,
  output logic                  irqEn,
  output logic [NUM_REGS*8-1:0] ctlRegs
);
  logic unusedWdata;
  assign unusedWdata = ^hostWdata[7:1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ownAddr   <= DEF_ADDR;
      rxData    <= '0;
      statusBit <= 1'b0;
      irqEn     <= 1'b0;
    end else begin
      if (hostWe && hostAddr == OFS_ADDR) ownAddr <= hostWdata[6:0];
      if (hostWe && hostAddr == OFS_EN)   irqEn   <= hostWdata[0];
      if (stb.commit) begin
        rxData    <= stb.data;
        statusBit <= 1'b1;
      end else if (hostWe && hostAddr == OFS_STAT && hostWdata[0]) begin
        statusBit <= 1'b0;
      end
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_ctl
    always_ff @(posedge clk) begin
      if (!rstN) ctlRegs[g*8 +: 8] <= '0;
      else if (stb.commit && stb.cmd == 8'(g)) ctlRegs[g*8 +: 8] <= stb.data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) hostRdata <= '0;
    else begin
      unique case (hostAddr)
        OFS_ADDR: hostRdata <= {1'b0, ownAddr};
        OFS_DATA: hostRdata <= rxData;
        OFS_STAT: hostRdata <= {7'd0, statusBit};
        default:  hostRdata <= {7'd0, irqEn};
      endcase
    end
  end
endmodule

// File: rtl/smbw_slave.sv
module smbw_slave
  import smbw_pkg::*;
#(
  parameter int         NUM_REGS    = 4,
  parameter logic [6:0] DEF_ADDR    = 7'h44,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sclIn,
  input  logic                  sdaIn,
  output logic                  sdaDrvLow,
  input  logic                  hostWe,
  input  logic [1:0]            hostAddr,
  input  logic [7:0]            hostWdata,
  output logic [7:0]            hostRdata,
  output logic                  irq,
  output logic [NUM_REGS*8-1:0] ctlRegs
);
  smbwStrobe_t stb;
  logic [6:0]  ownAddr;
  logic [7:0]  rxData;
  logic        statusBit, irqEn;

  smbw_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .ownAddr(ownAddr), .sdaDrvLow(sdaDrvLow), .stb(stb)
  );

  smbw_dpath #(.NUM_REGS(NUM_REGS), .DEF_ADDR(DEF_ADDR)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .hostWe(hostWe), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .ownAddr(ownAddr),
    .rxData(rxData), .statusBit(statusBit), .irqEn(irqEn), .ctlRegs(ctlRegs)
  );

  assign irq = statusBit & irqEn;
endmodule

// File: rtl/smbw_chk.sv
module smbw_chk #(
  parameter int NUM_REGS = 4
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  sclIn,
  input logic                  sdaDrvLow,
  input logic                  hostWe,
  input logic [1:0]            hostAddr,
  input logic                  commit,
  input logic [7:0]            cmdData,
  input logic                  statusBit,
  input logic [7:0]            rxData,
  input logic [6:0]            ownAddr,
  input logic [NUM_REGS*8-1:0] ctlRegs
);
  AST_DRV_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaDrvLow) |-> !sclIn); // R11
  AST_RELEASE_AT_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    commit |=> !sdaDrvLow); // R11
  AST_STATUS_SET: assert property (@(posedge clk) disable iff (!rstN)
    commit |=> statusBit); // R6
  AST_STATUS_SRC: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusBit) |-> $past(commit)); // R6
  AST_RXDATA_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    commit |=> rxData == $past(cmdData)); // R5
  AST_CTL_ONLY_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(ctlRegs) |-> $past(commit)); // R4
  AST_ADDR_ONLY_HOST: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(ownAddr) |-> ($past(hostWe) && $past(hostAddr) == 2'd0)); // R9
endmodule

bind smbw_slave smbw_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaDrvLow(sdaDrvLow),
  .hostWe(hostWe), .hostAddr(hostAddr), .commit(stb.commit),
  .cmdData(stb.data), .statusBit(statusBit), .rxData(rxData),
  .ownAddr(ownAddr), .ctlRegs(ctlRegs)
);

// File: tb/smbw_slave_tb.sv
module smbw_slave_tb_top;
  localparam int NREG = 4;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclLine = 1'b1, mSda = 1'b1;
  logic sdaDrvLow, irq;
  logic hostWe = 1'b0;
  logic [1:0] hostAddr = '0;
  logic [7:0] hostWdata = '0, hostRdata;
  logic [NREG*8-1:0] ctlRegs;
  logic sdaBus;

  int checks = 0, errors = 0;
  logic [6:0] mOwn = 7'h44;
  logic [7:0] mRx = '0;
  logic mStat = 1'b0, mEn = 1'b0;
  logic [7:0] mRegs [NREG];

  assign sdaBus = mSda & ~sdaDrvLow;
  always #10 clk = ~clk;

  smbw_slave #(.NUM_REGS(NREG)) dut_i (
    .clk(clk), .rstN(rstN), .sclIn(sclLine), .sdaIn(sdaBus), .sdaDrvLow(sdaDrvLow),
    .hostWe(hostWe), .hostAddr(hostAddr), .hostWdata(hostWdata),
    .hostRdata(hostRdata), .irq(irq), .ctlRegs(ctlRegs)
  );

  function automatic bit expAck(logic [6:0] a, bit rw, logic [6:0] own);
    return (a == own) && !rw;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitQ(int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic doStart();
    if (!sclLine) begin
      mSda = 1'b1; waitQ(1);
      sclLine = 1'b1; waitQ(1);
    end
    mSda = 1'b0; waitQ(1);
    sclLine = 1'b0; waitQ(1);
  endtask

  task automatic doStop();
    mSda = 1'b0; waitQ(1);
    sclLine = 1'b1; waitQ(1);
    mSda = 1'b1; waitQ(2);
  endtask

  task automatic sendByte(logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      mSda = b[i]; waitQ(1);
      sclLine = 1'b1; waitQ(2);
      sclLine = 1'b0; waitQ(1);
    end
    mSda = 1'b1; waitQ(1);
    sclLine = 1'b1; waitQ(1);
    acked = !sdaBus;
    waitQ(1);
    sclLine = 1'b0; waitQ(1);
  endtask

  // abortKind: 0 full message, 1 stop after command, 2 no stop after command (repeated start follows)
  task automatic sendMsg(logic [6:0] a, bit rw, logic [7:0] cmd, logic [7:0] d, int abortKind);
    bit ack;
    bit exp;
    exp = expAck(a, rw, mOwn);
    doStart();
    sendByte({a, rw}, ack);
    chk(exp ? "R2 address ack" : "R3 address no-ack", 32'(ack), 32'(exp));
    sendByte(cmd, ack);
    chk(exp ? "R2 command ack" : "R3 command no-ack", 32'(ack), 32'(exp));
    if (abortKind == 1) begin doStop(); return; end
    if (abortKind == 2) return;
    sendByte(d, ack);
    chk(exp ? "R2 data ack" : "R3 data no-ack", 32'(ack), 32'(exp));
    doStop();
    if (exp) begin
      mRx = d;
      mStat = 1'b1;
      if (cmd < NREG) mRegs[cmd] = d;
    end
  endtask

  task automatic hostWrite(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    hostWe = 1'b1; hostAddr = a; hostWdata = d;
    @(negedge clk);
    hostWe = 1'b0;
  endtask

  task automatic hostRead(logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    hostAddr = a;
    @(negedge clk);
    d = hostRdata;
  endtask

  task automatic verifyAll(string tag);
    logic [7:0] r;
    hostRead(2'd0, r); chk({tag, " R10 R9 own address"}, 32'(r), 32'({1'b0, mOwn}));
    hostRead(2'd1, r); chk({tag, " R5 received data"}, 32'(r), 32'(mRx));
    hostRead(2'd2, r); chk({tag, " R6 status"}, 32'(r), 32'({7'd0, mStat}));
    hostRead(2'd3, r); chk({tag, " R7 enable"}, 32'(r), 32'({7'd0, mEn}));
    for (int i = 0; i < NREG; i++)
      chk({tag, " R4 control register"}, 32'(ctlRegs[i*8 +: 8]), 32'(mRegs[i]));
    chk({tag, " R7 irq"}, 32'(irq), 32'(mStat & mEn));
    chk({tag, " R11 no drive when idle"}, 32'(sdaDrvLow), 32'd0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] r;
    void'($urandom(32'd2024));
    for (int i = 0; i < NREG; i++) mRegs[i] = '0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 sdaDrvLow", 32'(sdaDrvLow), 32'd0);
    chk("R1 irq", 32'(irq), 32'd0);
    chk("R1 ctlRegs", 32'(ctlRegs), 32'd0);
    verifyAll("R1");

    // default address usable without programming (R1, R2, R4)
    sendMsg(7'h44, 1'b0, 8'd2, 8'hA5, 0);
    verifyAll("default-address");
    // R7 enable gates irq
    hostWrite(2'd3, 8'h01); mEn = 1'b1;
    @(negedge clk);
    chk("R7 irq enabled", 32'(irq), 32'd1);
    // R6 write-one clears, write-zero keeps
    hostWrite(2'd2, 8'h00);
    hostRead(2'd2, r); chk("R6 zero write keeps", 32'(r), 32'd1);
    hostWrite(2'd2, 8'h01); mStat = 1'b0;
    verifyAll("R6 clear");
    // R3 read bit set
    sendMsg(7'h44, 1'b1, 8'd1, 8'h11, 0);
    verifyAll("R3 read bit");
    // R4 out-of-range command still acks, updates data and status only
    sendMsg(7'h44, 1'b0, 8'd200, 8'h3C, 0);
    verifyAll("R4 out-of-range");
    // R8 stop after command aborts
    sendMsg(7'h44, 1'b0, 8'd0, 8'hEE, 1);
    verifyAll("R8 stop abort");
    // R8 repeated start after command aborts, new message decoded
    sendMsg(7'h44, 1'b0, 8'd1, 8'h77, 2);
    sendMsg(7'h44, 1'b0, 8'd3, 8'h5A, 0);
    verifyAll("R8 restart");
    // R9 new own address
    hostWrite(2'd0, 8'hB3); mOwn = 7'h33;
    sendMsg(7'h44, 1'b0, 8'd0, 8'h99, 0);
    sendMsg(7'h33, 1'b0, 8'd0, 8'h42, 0);
    verifyAll("R9 readdress");

    for (int n = 0; n < 36; n++) begin
      logic [6:0] a;
      int sel;
      sel = $urandom % 10;
      a = (sel < 7) ? mOwn : 7'($urandom);
      if (sel >= 7 && a == mOwn) a = a ^ 7'h01;
      sendMsg(a, ($urandom % 8) == 0, 8'($urandom % 6), 8'($urandom),
              (($urandom % 6) == 0) ? 1 : 0);
      sel = $urandom % 8;
      if (sel == 0) begin mEn = 1'($urandom); hostWrite(2'd3, {7'd0, mEn}); end
      else if (sel == 1) begin hostWrite(2'd2, 8'hFF); mStat = 1'b0; end
      else if (sel == 2) begin mOwn = 7'($urandom); hostWrite(2'd0, {1'b1, mOwn}); end
      verifyAll("random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule